// File: doc/BRIEF.md
# Doorbell Dispatch-Index Writer

This block serves store requests aimed at a command queue's doorbell. Several requesters may ask at once. A round-robin arbiter picks one of them, and that winner takes a single ownership flag by changing it from free to held. A requester that is not picked keeps its request raised and retries on later cycles.

While the flag is held, the block works out the dispatch index from the winner's signalled value, or from the queue's read and write pointers. It raises the 64-bit maximum-signalled register if the new index is larger. It then presents the index on a doorbell write channel as one write. When the interconnect accepts that write, the flag returns to free and the owner receives a one-cycle completion pulse.

Two mode inputs shape the index. One clamps the index for the small address model. The other folds the index into a ring that is twice the queue size and then scales it to dword units.

Top module: `dbell_index_writer`

## Requirements
- R1: After reset the lock is free (`busy_o`=0), no grant is given, `db_valid_o`=0, `done_o`=0 and `max_sig_o`=0.
- R2: On the first clock edge where the lock is free and any `req_valid_i` bit is set, exactly one requester is granted and `busy_o` rises. At most one `grant_o` bit is ever set. Requests that arrive while the lock is held get no grant until it is released.
- R3: Round-robin order: the search starts at the requester just after the previous owner and wraps around. Just after reset the search starts at requester 0.
- R4: With both modes off, the doorbell value is the owner's signalled value plus 1, so it points past the last packet to process.
- R5: With `small_mode_i`=1, the signalled value is ignored. The index is min(`wr_idx_i`, `rd_idx_i` + `qsize_i`).
- R6: With `wrap_mode_i`=1, the index from R4 or R5 is reduced as ((index AND (2·`qsize_i` − 1)) shifted left by 4). `qsize_i` is a power of two.
- R7: `max_sig_o` takes the unwrapped index from R4 or R5 only when that index is larger, so it never decreases.
- R8: `db_valid_o` rises in the same edge that takes the lock. `db_data_o` holds steady until `db_ready_i` is sampled high. Exactly one write is made per ownership.
- R9: On the edge where the write is accepted, the lock is freed, `db_valid_o` falls, and the owner's `done_o` bit pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | N_REQ | Store request per requester, held until done |
| req_value_i | input | N_REQ*IDX_W | Signalled value per requester (requester k at bits k*IDX_W upward) |
| wr_idx_i | input | IDX_W | Queue write index |
| rd_idx_i | input | IDX_W | Queue read index |
| qsize_i | input | IDX_W | Queue size in packets, a power of two |
| small_mode_i | input | 1 | Small-model clamp select |
| wrap_mode_i | input | 1 | Ring wrap and dword scaling select |
| db_ready_i | input | 1 | Doorbell write accepted |
| db_valid_o | output | 1 | Doorbell write pending |
| db_data_o | output | IDX_W | Doorbell index value |
| max_sig_o | output | IDX_W | Maximum-signalled register |
| busy_o | output | 1 | Lock held |
| grant_o | output | N_REQ | One-hot current owner |
| done_o | output | N_REQ | One-cycle completion pulse to owner |

## Verification
Acquisition, index, maximum register and grant all come from registers loaded on one edge. They are therefore due one edge after a request is seen with the lock free. Release and the completion pulse are due one edge after `db_ready_i` is sampled high. The bench drives inputs on falling edges, waits exactly one rising edge, and samples at the next falling edge. Hold checks keep `db_ready_i` low over several edges and confirm that the data has not moved and no completion has appeared.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  typedef enum logic {
    ST_FREE = 1'b0,
    ST_RING = 1'b1
  } dbell_state_e;
endpackage

// File: rtl/dbell_rr_arb.sv
module dbell_rr_arb #(
  parameter int N_REQ = 3,
  localparam int PTR_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic             take_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic [PTR_W-1:0] win_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    win_o = '0;
    for (int k = 1; k <= N_REQ; k++) begin
      int c;
      c = (int'(ptr_q) + k) % N_REQ;
      if (!found && req_i[c]) begin
        gnt_o[c] = 1'b1;
        win_o    = PTR_W'(c);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (take_i && (|req_i)) ptr_d = win_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= PTR_W'(N_REQ - 1);
    else        ptr_q <= ptr_d;
  end

  assert_arb_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  assert_arb_serves_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> ((gnt_o & req_i) != '0));
endmodule

// File: rtl/dbell_index_calc.sv
module dbell_index_calc #(
  parameter int IDX_W = 64
) (
  input  logic [IDX_W-1:0] value_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [IDX_W-1:0] qsize_i,
  input  logic             small_i,
  input  logic             wrap_i,
  output logic [IDX_W-1:0] base_o,
  output logic [IDX_W-1:0] ring_o
);
  logic [IDX_W-1:0] limit;
  logic [IDX_W-1:0] mask;

  always_comb begin
    limit  = rd_idx_i + qsize_i;
    mask   = (qsize_i << 1) - IDX_W'(1);
    if (small_i) base_o = (wr_idx_i < limit) ? wr_idx_i : limit;
    else         base_o = value_i + IDX_W'(1);
    if (wrap_i)  ring_o = (base_o & mask) << 4;
    else         ring_o = base_o;
  end
endmodule

// File: rtl/dbell_index_writer.sv
module dbell_index_writer
  import dbell_pkg::*;
#(
  parameter int N_REQ = 3,
  parameter int IDX_W = 64,
  localparam int PTR_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REQ-1:0]       req_valid_i,
  input  logic [N_REQ*IDX_W-1:0] req_value_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [IDX_W-1:0]       rd_idx_i,
  input  logic [IDX_W-1:0]       qsize_i,
  input  logic                   small_mode_i,
  input  logic                   wrap_mode_i,
  input  logic                   db_ready_i,
  output logic                   db_valid_o,
  output logic [IDX_W-1:0]       db_data_o,
  output logic [IDX_W-1:0]       max_sig_o,
  output logic                   busy_o,
  output logic [N_REQ-1:0]       grant_o,
  output logic [N_REQ-1:0]       done_o
);
  dbell_state_e     st_q, st_d;
  logic             lock_q, lock_d;
  logic [N_REQ-1:0] own_q, own_d;
  logic [N_REQ-1:0] done_q, done_d;
  logic [IDX_W-1:0] data_q, data_d;
  logic [IDX_W-1:0] max_q, max_d;
  logic [N_REQ-1:0] gnt;
  logic [PTR_W-1:0] win;
  logic [IDX_W-1:0] sel_value, base_idx, ring_idx;
  logic             cas_ok, accept;

  // Compare-and-swap succeeds only while the flag is free.
  assign cas_ok = (st_q == ST_FREE) && !lock_q && (|req_valid_i);
  assign accept = (st_q == ST_RING) && db_ready_i;

  dbell_rr_arb #(.N_REQ(N_REQ)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_valid_i),
    .take_i (cas_ok),
    .gnt_o  (gnt),
    .win_o  (win)
  );

  always_comb begin
    sel_value = '0;
    for (int k = 0; k < N_REQ; k++) begin
      if (int'(win) == k) sel_value = req_value_i[k*IDX_W +: IDX_W];
    end
  end

  dbell_index_calc #(.IDX_W(IDX_W)) u_calc (
    .value_i  (sel_value),
    .wr_idx_i (wr_idx_i),
    .rd_idx_i (rd_idx_i),
    .qsize_i  (qsize_i),
    .small_i  (small_mode_i),
    .wrap_i   (wrap_mode_i),
    .base_o   (base_idx),
    .ring_o   (ring_idx)
  );

  always_comb begin
    st_d   = st_q;
    lock_d = lock_q;
    own_d  = own_q;
    data_d = data_q;
    max_d  = max_q;
    done_d = '0;
    if (cas_ok) begin
      st_d   = ST_RING;
      lock_d = 1'b1;
      own_d  = gnt;
      data_d = ring_idx;
      if (base_idx > max_q) max_d = base_idx;
    end else if (accept) begin
      st_d   = ST_FREE;
      lock_d = 1'b0;
      done_d = own_q;
      own_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FREE;
      lock_q <= 1'b0;
      own_q  <= '0;
      done_q <= '0;
      data_q <= '0;
      max_q  <= '0;
    end else begin
      st_q   <= st_d;
      lock_q <= lock_d;
      own_q  <= own_d;
      done_q <= done_d;
      if (cas_ok) data_q <= data_d;
      if (cas_ok) max_q  <= max_d;
    end
  end

  assign db_valid_o = (st_q == ST_RING);
  assign db_data_o  = data_q;
  assign max_sig_o  = max_q;
  assign busy_o     = lock_q;
  assign grant_o    = own_q;
  assign done_o     = done_q;

  assert_one_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (busy_o == (grant_o != '0)));
  assert_max_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (max_sig_o >= $past(max_sig_o)));
  assert_db_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid_o && !db_ready_i) |=> (db_valid_o && $stable(db_data_o) && $stable(grant_o)));
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid_o && db_ready_i) |=> (!busy_o && !db_valid_o && $onehot(done_o)));
endmodule

// File: tb/tb_dbell_index_writer.sv
module tb_dbell_index_writer;
  localparam int N  = 3;
  localparam int W  = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req_valid;
  logic [N*W-1:0]  req_value;
  logic [W-1:0]    wr_idx, rd_idx, qsize;
  logic            small_mode, wrap_mode, db_ready;
  logic            db_valid, busy;
  logic [W-1:0]    db_data, max_sig;
  logic [N-1:0]    grant, done;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_max = '0;

  always #4 clk = ~clk;

  dbell_index_writer #(.N_REQ(N), .IDX_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_value_i(req_value),
    .wr_idx_i(wr_idx), .rd_idx_i(rd_idx), .qsize_i(qsize),
    .small_mode_i(small_mode), .wrap_mode_i(wrap_mode), .db_ready_i(db_ready),
    .db_valid_o(db_valid), .db_data_o(db_data), .max_sig_o(max_sig),
    .busy_o(busy), .grant_o(grant), .done_o(done)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Serve one ownership: acquisition, optional hold, acceptance, release.
  task automatic serve(input int o, input logic [W-1:0] d, input logic [W-1:0] base, input int hold);
    @(posedge clk); @(negedge clk);
    if (base > exp_max) exp_max = base;
    chk("R2 busy", W'(busy), 1);
    chk("R3 grant", W'(grant), W'(1 << o));
    chk("R8 db_valid", W'(db_valid), 1);
    chk("R4/R5/R6 db_data", db_data, d);
    chk("R7 max", max_sig, exp_max);
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 data held", db_data, d);
      chk("R8 no done", W'(done), 0);
    end
    db_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    db_ready = 1'b0;
    chk("R9 released", W'(busy), 0);
    chk("R9 db_valid low", W'(db_valid), 0);
    chk("R9 done", W'(done), W'(1 << o));
    req_valid[o] = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 done pulse", W'(done), 0);
  endtask

  task automatic set_val(input int o, input logic [W-1:0] v);
    req_value[o*W +: W] = v;
  endtask

  task automatic t_reset();
    chk("R1 busy", W'(busy), 0);
    chk("R1 grant", W'(grant), 0);
    chk("R1 db_valid", W'(db_valid), 0);
    chk("R1 done", W'(done), 0);
    chk("R1 max", max_sig, 0);
  endtask

  task automatic t_plain();
    small_mode = 0; wrap_mode = 0;
    set_val(0, 64'd9); req_valid[0] = 1'b1;
    serve(0, 64'd10, 64'd10, 2);
  endtask

  task automatic t_small();
    small_mode = 1; wrap_mode = 0;
    wr_idx = 50; rd_idx = 20; qsize = 16;
    set_val(0, 64'd999); req_valid[0] = 1'b1;
    serve(0, 64'd36, 64'd36, 0);
    wr_idx = 30;
    set_val(0, 64'd999); req_valid[0] = 1'b1;
    serve(0, 64'd30, 64'd30, 0);
    chk("R7 no decrease", max_sig, 64'd36);
  endtask

  task automatic t_wrap();
    small_mode = 0; wrap_mode = 1; qsize = 16;
    set_val(0, 64'd40); req_valid[0] = 1'b1;
    serve(0, 64'd144, 64'd41, 0);
    small_mode = 1; wr_idx = 100; rd_idx = 5; qsize = 8;
    req_valid[0] = 1'b1;
    serve(0, 64'd208, 64'd13, 1);
  endtask

  task automatic t_round_robin();
    small_mode = 0; wrap_mode = 0;
    set_val(0, 64'd100); set_val(1, 64'd200); set_val(2, 64'd300);
    req_valid = '1;
    serve(1, 64'd201, 64'd201, 0);
    serve(2, 64'd301, 64'd301, 0);
    serve(0, 64'd101, 64'd101, 0);
  endtask

  task automatic t_no_grant_while_held();
    small_mode = 0; wrap_mode = 0;
    set_val(1, 64'd500); req_valid[1] = 1'b1;
    @(posedge clk); @(negedge clk);
    set_val(2, 64'd700); req_valid[2] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 owner kept", W'(grant), W'(2));
    chk("R2 data kept", db_data, 64'd501);
    db_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    db_ready = 1'b0; req_valid[1] = 1'b0;
    chk("R9 done owner", W'(done), W'(2));
    if (64'd501 > exp_max) exp_max = 64'd501;
    serve(2, 64'd701, 64'd701, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = '0; req_value = '0;
    wr_idx = '0; rd_idx = '0; qsize = 64'd16;
    small_mode = 1'b0; wrap_mode = 1'b0; db_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_small();
    t_wrap();
    t_round_robin();
    t_no_grant_while_held();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule